// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This unit sits beside the element sequencer of a vector loop. A loop is opened with a start pulse that carries the requested vector length and a small configuration word. After that, one element outcome arrives per valid beat, in element order. For each element the unit decides at once whether that element's result and condition field may be written back. It also decides whether the loop must end early. If it does, the unit produces the shortened vector length one cycle later.

There are two policies. In memory mode, each element brings a fault flag. A fault on the first element is reported as an ordinary exception. A fault on any later element quietly shortens the vector to the elements already completed. In condition mode, each element brings a 4-bit condition field. One chosen bit is compared against an inversion flag, and a match cuts the loop. The new length counts the elements before the failing one, plus that element itself when the inclusive option is in force. Condition mode is the only path that can produce a length of zero.

Top module: `ff_trunc_unit`

## Requirements
- R1: After reset, stop_o, busy_o, vl_o, exc_o, res_we_o and cr_we_o are all zero.
- R2: A start_i pulse loads vl_o with vl_i and clears stop_o from the next cycle. busy_o becomes 1 only if vl_i is nonzero. The element index restarts at 0. An element presented in the same cycle as start_i is ignored.
- R3: In memory mode (mode_i=0), a fault on element 0 raises exc_o in the same cycle with res_we_o low. From the next cycle busy_o is 0, while stop_o stays 0 and vl_o is unchanged.
- R4: In memory mode, a fault on element k≥1 gives res_we_o=0 for that element, and from the next cycle stop_o=1 and vl_o=k. Memory mode never yields vl_o=0 through truncation.
- R5: In condition mode (mode_i=1), cr_i[3]=lt, cr_i[2]=gt, cr_i[1]=eq and cr_i[0]=so. The tested bit is cr_i[3-bit_sel_i] (bit_sel_i 0=lt, 1=gt, 2=eq, 3=so). The element fails when that bit equals inv_i. From the next cycle stop_o=1 and vl_o=k, or k+1 when inclusive is effective, where k is the failing index. A failure on element 0 that is not inclusive gives vl_o=0.
- R6: Inclusive is effective only when incl_i=1, rc_i=0 and rc1_i=0. Otherwise incl_i has no effect on vl_o or on the write enables.
- R7: In memory mode, res_we_o is the inverse of the element's fault flag and cr_we_o is 0. In condition mode, cr_we_o is 1 for a passing element when rc_i or rc1_i is set. res_we_o is 1 for a passing element, or for a failing element with inclusive effective.
- R8: With rc1_i=1 in condition mode, res_we_o is never asserted.
- R9: If no element triggers a stop, busy_o falls after element vl-1, vl_o keeps the loaded value and stop_o stays 0.
- R10: Elements presented while busy_o is 0 produce no write enable and no exception, and they change neither vl_o nor stop_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a loop and latches configuration |
| vl_i | input | VLW | Requested vector length (at most MAX_VL) |
| mode_i | input | 1 | 0 memory, 1 condition |
| bit_sel_i | input | 2 | Condition bit selector |
| inv_i | input | 1 | Value of the tested bit that fails |
| incl_i | input | 1 | Keep the failing element |
| rc_i | input | 1 | Condition field recording enabled |
| rc1_i | input | 1 | Condition-only recording, results suppressed |
| elem_valid_i | input | 1 | Element outcome present |
| elem_fault_i | input | 1 | Element would fault (memory mode) |
| elem_cr_i | input | 4 | Element condition field {lt,gt,eq,so} |
| res_we_o | output | 1 | Write the element result |
| cr_we_o | output | 1 | Write the element condition field |
| exc_o | output | 1 | Raise exception for element 0 |
| busy_o | output | 1 | Loop accepting elements |
| stop_o | output | 1 | Loop ended early |
| vl_o | output | VLW | Current or truncated vector length |

## Verification
The hardest states to reach are the edges of the truncated length. These are a condition failure on element 0 that yields zero, the same failure with inclusive effective that yields one, and a fault on the last element of a loop. Random loops cover these only rarely. Directed loops therefore place the failing element at index 0, index 1 and index vl-1. Random loops with short lengths and a biased fault rate, mixed with every combination of rc and rc1, cover the rest of the space.

// File: rtl/ff_trunc_pkg.sv
package ff_trunc_pkg;
  typedef enum logic {
    FF_MEM  = 1'b0,
    FF_COND = 1'b1
  } ff_mode_e;

  typedef struct packed {
    ff_mode_e   mode;
    logic [1:0] bit_sel;
    logic       inv;
    logic       incl;
    logic       rc;
    logic       rc1;
  } ff_cfg_t;
endpackage

// File: rtl/ff_elem_eval.sv
module ff_elem_eval
  import ff_trunc_pkg::*;
#(
  parameter int unsigned VLW = 7
) (
  input  ff_cfg_t        cfg_i,
  input  logic           act_i,
  input  logic [VLW-1:0] idx_i,
  input  logic           fault_i,
  input  logic [3:0]     cr_i,
  output logic           fail_o,
  output logic           exc_o,
  output logic [VLW-1:0] new_vl_o,
  output logic           res_we_o,
  output logic           cr_we_o
);
  logic first;
  logic tested;
  logic hit;
  logic incl_eff;

  assign first    = (idx_i == '0);
  assign tested   = cr_i[2'd3 - cfg_i.bit_sel];
  assign hit      = (tested == cfg_i.inv);
  // inclusive only meaningful without any condition recording
  assign incl_eff = cfg_i.incl & ~cfg_i.rc & ~cfg_i.rc1;

  always_comb begin
    fail_o   = 1'b0;
    exc_o    = 1'b0;
    new_vl_o = idx_i;
    res_we_o = 1'b0;
    cr_we_o  = 1'b0;
    if (act_i) begin
      if (cfg_i.mode == FF_MEM) begin
        fail_o   = fault_i & ~first;
        exc_o    = fault_i & first;
        res_we_o = ~fault_i;
      end else begin
        fail_o   = hit;
        new_vl_o = idx_i + VLW'(incl_eff);
        res_we_o = ~cfg_i.rc1 & (~hit | incl_eff);
        cr_we_o  = (cfg_i.rc | cfg_i.rc1) & ~hit;
      end
    end
  end
endmodule

// File: rtl/ff_loop_ctrl.sv
module ff_loop_ctrl
  import ff_trunc_pkg::*;
#(
  parameter int unsigned VLW = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  ff_cfg_t        cfg_d_i,
  input  logic           act_i,
  input  logic           fail_i,
  input  logic           exc_i,
  input  logic [VLW-1:0] new_vl_i,
  output ff_cfg_t        cfg_q_o,
  output logic [VLW-1:0] idx_o,
  output logic           busy_o,
  output logic           stop_o,
  output logic [VLW-1:0] vl_o
);
  ff_cfg_t        cfg_q;
  logic [VLW-1:0] idx_q;
  logic [VLW-1:0] idx_nxt;
  logic [VLW-1:0] vl_q;
  logic           busy_q;
  logic           stop_q;

  assign idx_nxt = idx_q + VLW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      idx_q  <= '0;
      vl_q   <= '0;
      busy_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (start_i) begin
      cfg_q  <= cfg_d_i;
      idx_q  <= '0;
      vl_q   <= vl_i;
      busy_q <= (vl_i != '0);
      stop_q <= 1'b0;
    end else if (act_i) begin
      if (fail_i) begin
        stop_q <= 1'b1;
        busy_q <= 1'b0;
        vl_q   <= new_vl_i;
      end else if (exc_i) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_nxt;
        if (idx_nxt == vl_q) busy_q <= 1'b0;
      end
    end
  end

  assign cfg_q_o = cfg_q;
  assign idx_o   = idx_q;
  assign busy_o  = busy_q;
  assign stop_o  = stop_q;
  assign vl_o    = vl_q;
endmodule

// File: rtl/ff_trunc_unit.sv
module ff_trunc_unit
  import ff_trunc_pkg::*;
#(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned VLW   = $clog2(MAX_VL + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           mode_i,
  input  logic [1:0]     bit_sel_i,
  input  logic           inv_i,
  input  logic           incl_i,
  input  logic           rc_i,
  input  logic           rc1_i,
  input  logic           elem_valid_i,
  input  logic           elem_fault_i,
  input  logic [3:0]     elem_cr_i,
  output logic           res_we_o,
  output logic           cr_we_o,
  output logic           exc_o,
  output logic           busy_o,
  output logic           stop_o,
  output logic [VLW-1:0] vl_o
);
  ff_cfg_t        cfg_d;
  ff_cfg_t        cfg_q;
  logic [VLW-1:0] idx;
  logic [VLW-1:0] new_vl;
  logic           act;
  logic           fail;
  logic           exc;
  logic           busy;
  logic           cfg_rc1_q;
  logic           cfg_cond_q;

  assign cfg_d = '{mode: ff_mode_e'(mode_i), bit_sel: bit_sel_i, inv: inv_i,
                   incl: incl_i, rc: rc_i, rc1: rc1_i};

  // start wins over a same-cycle element
  assign act = busy & elem_valid_i & ~start_i;

  ff_elem_eval #(.VLW(VLW)) u_eval (
    .cfg_i    (cfg_q),
    .act_i    (act),
    .idx_i    (idx),
    .fault_i  (elem_fault_i),
    .cr_i     (elem_cr_i),
    .fail_o   (fail),
    .exc_o    (exc),
    .new_vl_o (new_vl),
    .res_we_o (res_we_o),
    .cr_we_o  (cr_we_o)
  );

  ff_loop_ctrl #(.VLW(VLW)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .cfg_d_i  (cfg_d),
    .act_i    (act),
    .fail_i   (fail),
    .exc_i    (exc),
    .new_vl_i (new_vl),
    .cfg_q_o  (cfg_q),
    .idx_o    (idx),
    .busy_o   (busy),
    .stop_o   (stop_o),
    .vl_o     (vl_o)
  );

  assign exc_o      = exc;
  assign busy_o     = busy;
  assign cfg_rc1_q  = cfg_q.rc1;
  assign cfg_cond_q = (cfg_q.mode == FF_COND);
endmodule

// File: rtl/ff_trunc_chk.sv
module ff_trunc_chk #(
  parameter int unsigned VLW = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           elem_valid_i,
  input logic           res_we_o,
  input logic           cr_we_o,
  input logic           exc_o,
  input logic           busy_o,
  input logic           stop_o,
  input logic [VLW-1:0] vl_o,
  input logic           cfg_rc1_q,
  input logic           cfg_cond_q
);
  // R4: memory-mode truncation never reaches zero
  p_mem_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o && !cfg_cond_q |-> vl_o != '0);

  // R5: truncation never grows the length
  p_shrink_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> vl_o <= $past(vl_o));

  // R5: stop only follows an accepted element
  p_stop_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_o) |-> $past(elem_valid_i && busy_o && !start_i));

  // R2: stop holds until the next start
  p_stop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o && !start_i |=> stop_o);

  // R8: condition-only recording never writes results
  p_rc1_nores_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rc1_q && cfg_cond_q |-> !res_we_o);

  // R10: idle loop emits nothing
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !res_we_o && !cr_we_o && !exc_o);

  // R3: first-element exception ends loop without truncation
  p_exc_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> !busy_o && !stop_o && $stable(vl_o));
endmodule

bind ff_trunc_unit ff_trunc_chk #(.VLW(VLW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .elem_valid_i (elem_valid_i),
  .res_we_o     (res_we_o),
  .cr_we_o      (cr_we_o),
  .exc_o        (exc_o),
  .busy_o       (busy_o),
  .stop_o       (stop_o),
  .vl_o         (vl_o),
  .cfg_rc1_q    (cfg_rc1_q),
  .cfg_cond_q   (cfg_cond_q)
);

// File: tb/ff_trunc_unit_test.sv
`timescale 1ns/1ps
module ff_trunc_unit_test;
  localparam int unsigned MAX_VL = 64;
  localparam int unsigned VLW    = $clog2(MAX_VL + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [VLW-1:0] vl_in = '0;
  logic           mode = 1'b0;
  logic [1:0]     bsel = '0;
  logic           inv = 1'b0, incl = 1'b0, rc = 1'b0, rc1 = 1'b0;
  logic           ev = 1'b0, ef = 1'b0;
  logic [3:0]     ecr = '0;
  logic           res_we, cr_we, exc, busy, stop;
  logic [VLW-1:0] vl_out;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  int m_idx, m_vl;
  bit m_busy, m_stop;
  bit c_mode, c_inv, c_incl, c_rc, c_rc1;
  int c_bsel;

  always #2 clk = ~clk;

  ff_trunc_unit #(.MAX_VL(MAX_VL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl_in),
    .mode_i(mode), .bit_sel_i(bsel), .inv_i(inv), .incl_i(incl),
    .rc_i(rc), .rc1_i(rc1), .elem_valid_i(ev), .elem_fault_i(ef),
    .elem_cr_i(ecr), .res_we_o(res_we), .cr_we_o(cr_we), .exc_o(exc),
    .busy_o(busy), .stop_o(stop), .vl_o(vl_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    chk({tag, " busy"}, int'(busy), int'(m_busy));
    chk({tag, " stop"}, int'(stop), int'(m_stop));
    chk({tag, " vl"}, int'(vl_out), m_vl);
  endtask

  task automatic do_start(bit md, int vl, int bs, bit iv, bit inc,
                          bit r, bit r1, bit with_elem);
    start = 1'b1; vl_in = VLW'(vl); mode = md; bsel = 2'(bs);
    inv = iv; incl = inc; rc = r; rc1 = r1;
    ev = with_elem; ef = 1'b1; ecr = 4'hF;
    #1;
    if (with_elem) begin
      chk("R2 same-cycle res_we", int'(res_we), 0);
      chk("R2 same-cycle exc", int'(exc), 0);
    end
    @(posedge clk); @(negedge clk);
    start = 1'b0; ev = 1'b0;
    c_mode = md; c_bsel = bs; c_inv = iv; c_incl = inc; c_rc = r; c_rc1 = r1;
    m_idx = 0; m_vl = vl; m_busy = (vl != 0); m_stop = 0;
    chk_regs("R2");
  endtask

  task automatic do_elem(string tag, bit f, logic [3:0] cr);
    bit act, hit, ie, e_fail, e_exc, e_rwe, e_cwe;
    int nv;
    ev = 1'b1; ef = f; ecr = cr;
    #1;
    act = m_busy;
    ie = c_incl & ~c_rc & ~c_rc1;
    hit = (cr[3 - c_bsel] == c_inv);
    e_fail = 0; e_exc = 0; e_rwe = 0; e_cwe = 0; nv = m_idx;
    if (act) begin
      if (!c_mode) begin
        e_fail = f && m_idx != 0;
        e_exc = f && m_idx == 0;
        e_rwe = !f;
      end else begin
        e_fail = hit;
        nv = m_idx + int'(ie);
        e_rwe = !c_rc1 && (!hit || ie);
        e_cwe = (c_rc || c_rc1) && !hit;
      end
    end
    chk({tag, " res_we"}, int'(res_we), int'(e_rwe));
    chk({tag, " cr_we"}, int'(cr_we), int'(e_cwe));
    chk({tag, " exc"}, int'(exc), int'(e_exc));
    @(posedge clk); @(negedge clk);
    ev = 1'b0;
    if (act) begin
      if (e_fail) begin m_stop = 1; m_busy = 0; m_vl = nv; end
      else if (e_exc) m_busy = 0;
      else begin m_idx++; if (m_idx == m_vl) m_busy = 0; end
    end
    chk_regs(tag);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1 stop", int'(stop), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 vl", int'(vl_out), 0);
    chk("R1 res_we", int'(res_we), 0);
    chk("R1 cr_we", int'(cr_we), 0);
    chk("R1 exc", int'(exc), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_idx = 0; m_vl = 0; m_busy = 0; m_stop = 0;
    c_mode = 0; c_bsel = 0; c_inv = 0; c_incl = 0; c_rc = 0; c_rc1 = 0;
    @(negedge clk);

    // R10: element while idle
    do_elem("R10", 1'b1, 4'hF);
    // R2: start ignores same-cycle element; zero length stays idle
    do_start(1'b0, 0, 0, 0, 0, 0, 0, 1'b1);
    do_elem("R10", 1'b0, 4'h0);
    // R3: fault on element 0
    do_start(1'b0, 5, 0, 0, 0, 0, 0, 1'b1);
    do_elem("R3", 1'b1, 4'h0);
    do_elem("R10", 1'b1, 4'h0);
    // R4: fault at element 1 and at last element
    do_start(1'b0, 6, 0, 0, 0, 0, 0, 1'b0);
    do_elem("R4", 1'b0, 4'h0);
    do_elem("R4", 1'b1, 4'h0);
    chk("R4 vl=1", int'(vl_out), 1);
    do_start(1'b0, 4, 0, 0, 0, 0, 0, 1'b0);
    for (int i = 0; i < 3; i++) do_elem("R4", 1'b0, 4'h0);
    do_elem("R4", 1'b1, 4'h0);
    chk("R4 vl=3", int'(vl_out), 3);
    // R5: condition fail on element 0, eq bit (sel 2), inv=1 -> zero
    do_start(1'b1, 8, 2, 1, 0, 0, 0, 1'b0);
    do_elem("R5", 1'b0, 4'b0010);
    chk("R5 vl=0", int'(vl_out), 0);
    chk("R5 stop", int'(stop), 1);
    // R6: inclusive keeps failing element
    do_start(1'b1, 8, 0, 0, 1, 0, 0, 1'b0);
    do_elem("R6", 1'b0, 4'b0111);
    chk("R6 vl=1", int'(vl_out), 1);
    // R6: inclusive ignored with rc
    do_start(1'b1, 8, 0, 0, 1, 1, 0, 1'b0);
    do_elem("R6", 1'b0, 4'b1000);
    do_elem("R6", 1'b0, 4'b0000);
    chk("R6 vl=1 rc", int'(vl_out), 1);
    // R8: rc1 never writes results
    do_start(1'b1, 3, 3, 1, 1, 0, 1, 1'b0);
    do_elem("R8", 1'b0, 4'b0000);
    do_elem("R8", 1'b0, 4'b0001);
    chk("R8 vl=1", int'(vl_out), 1);
    // R9: no trigger passes length through
    do_start(1'b1, 5, 1, 1, 0, 1, 0, 1'b0);
    for (int i = 0; i < 5; i++) do_elem("R9", 1'b0, 4'b1011);
    chk("R9 vl", int'(vl_out), 5);
    chk("R9 stop", int'(stop), 0);
    do_elem("R10", 1'b0, 4'b0100);

    // R7: random loops
    for (int l = 0; l < 300; l++) begin
      bit md;
      int vl;
      md = 1'($urandom % 2);
      vl = int'($urandom % 13);
      do_start(md, vl, int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
               1'($urandom % 2), 1'(($urandom % 4) == 0), 1'($urandom % 2));
      for (int e = 0; e < vl + 2; e++)
        do_elem(md ? "R7/R5" : "R7/R4", 1'(($urandom % 8) == 0), 4'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule